// File: doc/BRIEF.md
# BCD Time Event and Status Controller

This block sits beside a set of free-running BCD time and calendar counters. On every clock it compares the counter values with those of the previous cycle. From that comparison it raises a second event, a time event and a calendar event. The time event is chosen from minute, hour, midnight or noon boundaries. The calendar event is chosen from week, month or year boundaries. Three further one-cycle pulses, an alarm match, an update acknowledge and a counter error, are also folded into the status.

Every event sets a sticky status flag that stays set until software clears it with a write-one-to-clear command. A mask register is written through separate enable and disable strobes. One registered interrupt line is raised whenever a set flag has its mask bit on.

Status and mask bit positions:

| Bit | Source |
| --- | --- |
| 0 | update acknowledge |
| 1 | alarm |
| 2 | second event |
| 3 | time event |
| 4 | calendar event |
| 5 | time/date error |

Top module: `time_event_status`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `status`, `mask` and `irq` are all zero.
- R2: Status bit 2 is set on the clock where `secBcd` differs from its value on the previous clock.
- R3: With `timeSel` = 0, status bit 3 is set when `minBcd` changes while `secBcd` is 0x00. With `timeSel` = 1, it is set when `hourBcd` changes while minutes and seconds are 0x00.
- R4: With `timeSel` = 2, status bit 3 is set when the time changes into 00:00:00. With `timeSel` = 3, it is set when the time changes into 12:00:00, where the hour is BCD 0x12.
- R5: At the change into 00:00:00, status bit 4 is set as follows, depending on `calSel`:
  - `calSel` = 0: `dayOfWeek` is 1, meaning Monday.
  - `calSel` = 1: `dateBcd` is 0x01.
  - `calSel` = 2: `dateBcd` is 0x01 and `monthBcd` is 0x01.
- R6: With `calSel` = 3, status bit 4 is never set.
- R7: An event is raised only once per boundary. Holding the counter inputs steady raises no further event, so a flag that has been cleared stays clear. No event is raised in the first cycle after reset.
- R8: A one-cycle pulse on `updAck`, `alarmHit` or `timeErr` sets status bit 0, 1 or 5 respectively. The flag stays set after the pulse ends.
- R9: When `clrWr` is high, each bit of `wrData` that is 1 clears the matching status bit on the next clock. Bits that are 0 leave their flags unchanged, and no flag ever falls without such a clear.
- R10: When a flag's set condition and its clear command fall on the same clock, the flag ends up set.
- R11: `ienWr` sets the mask bits selected by the ones in `wrData`, and `idisWr` clears them. When both strobes hit the same bit on one clock, that mask bit ends up cleared.
- R12: `irq` equals the OR over all bits of (`status` AND `mask`) as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| secBcd | input | 7 | Current seconds, BCD |
| minBcd | input | 7 | Current minutes, BCD |
| hourBcd | input | 6 | Current hour, BCD, 24-hour form |
| dayOfWeek | input | 3 | Current weekday code, 1 = Monday |
| dateBcd | input | 6 | Current day of month, BCD |
| monthBcd | input | 5 | Current month, BCD |
| alarmHit | input | 1 | One-cycle alarm match pulse |
| updAck | input | 1 | One-cycle update acknowledge pulse |
| timeErr | input | 1 | One-cycle counter error pulse |
| timeSel | input | 2 | Time event select: 0 minute, 1 hour, 2 midnight, 3 noon |
| calSel | input | 2 | Calendar event select: 0 week, 1 month, 2 year, 3 none |
| wrData | input | 6 | Write data for the clear, enable and disable strobes |
| clrWr | input | 1 | Write-one-to-clear strobe for status |
| ienWr | input | 1 | Mask set strobe |
| idisWr | input | 1 | Mask clear strobe |
| status | output | 6 | Sticky status flags |
| mask | output | 6 | Current interrupt mask |
| irq | output | 1 | Registered combined interrupt |

## Verification
The counters are driven with pairs of consecutive times, and each pair is chosen so that only one condition separates it from a neighbouring case:
- A minute change with seconds at 59 is set against one with seconds at 00.
- A minute change is set against an hour change.
- 12:00:00 is reached both under the noon select and under the midnight select.
- Midnight is crossed on a Monday, on the first of a month, and on January 1, under each calendar select including the reserved one.

Inputs are then held still across several clocks to show that a boundary is counted once. Clear commands are issued in the same cycle as a new event, and with all-zero data. Enable and disable strobes are written together, to separate set-wins and disable-wins from the opposite choices. The interrupt line is sampled both in the cycle the mask turns on and in the cycle after, which exposes its one-clock lag.

// File: rtl/tev_pkg.sv
package tev_pkg;

  localparam int SEC_W    = 7;
  localparam int MIN_W    = 7;
  localparam int HOUR_W   = 6;
  localparam int DOW_W    = 3;
  localparam int DATE_W   = 6;
  localparam int MONTH_W  = 5;

  // Flag bit positions, shared by status, clear, enable and disable.
  localparam int FLG_ACK  = 0;
  localparam int FLG_ALM  = 1;
  localparam int FLG_SEC  = 2;
  localparam int FLG_TIM  = 3;
  localparam int FLG_CAL  = 4;
  localparam int FLG_ERR  = 5;
  localparam int NUM_FLAGS = 6;

  typedef enum logic [1:0] {
    TSEL_MINUTE   = 2'd0,
    TSEL_HOUR     = 2'd1,
    TSEL_MIDNIGHT = 2'd2,
    TSEL_NOON     = 2'd3
  } tsel_e;

  typedef enum logic [1:0] {
    CSEL_WEEK  = 2'd0,
    CSEL_MONTH = 2'd1,
    CSEL_YEAR  = 2'd2,
    CSEL_NONE  = 2'd3
  } csel_e;

  // Strobes from control to the flag datapath.
  typedef struct packed {
    logic [NUM_FLAGS-1:0] setVec;
    logic [NUM_FLAGS-1:0] clrVec;
    logic [NUM_FLAGS-1:0] ienVec;
    logic [NUM_FLAGS-1:0] idisVec;
  } strobe_t;

endpackage

// File: rtl/tev_event_detect.sv
module tev_event_detect
  import tev_pkg::*;
#(
  parameter logic [DOW_W-1:0]  MONDAY_CODE = 3'd1,
  parameter logic [HOUR_W-1:0] NOON_HOUR   = 6'h12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEC_W-1:0]     secBcd,
  input  logic [MIN_W-1:0]     minBcd,
  input  logic [HOUR_W-1:0]    hourBcd,
  input  logic [DOW_W-1:0]     dayOfWeek,
  input  logic [DATE_W-1:0]    dateBcd,
  input  logic [MONTH_W-1:0]   monthBcd,
  input  logic                 alarmHit,
  input  logic                 updAck,
  input  logic                 timeErr,
  input  logic [1:0]           timeSel,
  input  logic [1:0]           calSel,
  input  logic [NUM_FLAGS-1:0] wrData,
  input  logic                 clrWr,
  input  logic                 ienWr,
  input  logic                 idisWr,
  output strobe_t              strobe
);

  localparam logic [DATE_W-1:0]  FIRST_DATE  = DATE_W'(1);
  localparam logic [MONTH_W-1:0] FIRST_MONTH = MONTH_W'(1);

  logic [SEC_W-1:0]  prevSec;
  logic [MIN_W-1:0]  prevMin;
  logic [HOUR_W-1:0] prevHour;
  logic              primed;

  // Previous-sample registers; primed blocks events on the first cycle out of reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSec  <= '0;
      prevMin  <= '0;
      prevHour <= '0;
      primed   <= 1'b0;
    end else begin
      prevSec  <= secBcd;
      prevMin  <= minBcd;
      prevHour <= hourBcd;
      primed   <= 1'b1;
    end
  end

  logic secChg, minChg, hourChg, anyChg, topOfHour, atMidnight, atNoon;
  logic timeEvent, calEvent;
  tsel_e tSel;
  csel_e cSel;

  assign tSel = tsel_e'(timeSel);
  assign cSel = csel_e'(calSel);

  assign secChg    = primed && (secBcd  != prevSec);
  assign minChg    = primed && (minBcd  != prevMin);
  assign hourChg   = primed && (hourBcd != prevHour);
  assign anyChg    = secChg || minChg || hourChg;
  assign topOfHour = (minBcd == '0) && (secBcd == '0);
  assign atMidnight = anyChg && topOfHour && (hourBcd == '0);
  assign atNoon     = anyChg && topOfHour && (hourBcd == NOON_HOUR);

  always_comb begin
    unique case (tSel)
      TSEL_MINUTE:   timeEvent = minChg && (secBcd == '0);
      TSEL_HOUR:     timeEvent = hourChg && topOfHour;
      TSEL_MIDNIGHT: timeEvent = atMidnight;
      TSEL_NOON:     timeEvent = atNoon;
      default:       timeEvent = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cSel)
      CSEL_WEEK:  calEvent = atMidnight && (dayOfWeek == MONDAY_CODE);
      CSEL_MONTH: calEvent = atMidnight && (dateBcd == FIRST_DATE);
      CSEL_YEAR:  calEvent = atMidnight && (dateBcd == FIRST_DATE)
                             && (monthBcd == FIRST_MONTH);
      default:    calEvent = 1'b0;
    endcase
  end

  always_comb begin
    strobe.setVec          = '0;
    strobe.setVec[FLG_ACK] = updAck;
    strobe.setVec[FLG_ALM] = alarmHit;
    strobe.setVec[FLG_SEC] = secChg;
    strobe.setVec[FLG_TIM] = timeEvent;
    strobe.setVec[FLG_CAL] = calEvent;
    strobe.setVec[FLG_ERR] = timeErr;
    strobe.clrVec          = clrWr  ? wrData : '0;
    strobe.ienVec          = ienWr  ? wrData : '0;
    strobe.idisVec         = idisWr ? wrData : '0;
  end

endmodule

// File: rtl/tev_flag_bank.sv
module tev_flag_bank
  import tev_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  output logic [NUM_FLAGS-1:0] status,
  output logic [NUM_FLAGS-1:0] mask,
  output logic                 irq
);

  for (genvar b = 0; b < NUM_FLAGS; b++) begin : g_flag
    logic flagQ;
    logic maskQ;

    // Set dominates clear so an event that coincides with a clear survives.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ <= 1'b0;
      end else begin
        flagQ <= strobe.setVec[b] | (flagQ & ~strobe.clrVec[b]);
      end
    end

    // Disable dominates enable on the same bit.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ <= 1'b0;
      end else if (strobe.idisVec[b]) begin
        maskQ <= 1'b0;
      end else if (strobe.ienVec[b]) begin
        maskQ <= 1'b1;
      end
    end

    assign status[b] = flagQ;
    assign mask[b]   = maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else begin
      irq <= |(status & mask);
    end
  end

endmodule

// File: rtl/time_event_status.sv
module time_event_status
  import tev_pkg::*;
#(
  parameter logic [DOW_W-1:0]  MONDAY_CODE = 3'd1,
  parameter logic [HOUR_W-1:0] NOON_HOUR   = 6'h12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEC_W-1:0]     secBcd,
  input  logic [MIN_W-1:0]     minBcd,
  input  logic [HOUR_W-1:0]    hourBcd,
  input  logic [DOW_W-1:0]     dayOfWeek,
  input  logic [DATE_W-1:0]    dateBcd,
  input  logic [MONTH_W-1:0]   monthBcd,
  input  logic                 alarmHit,
  input  logic                 updAck,
  input  logic                 timeErr,
  input  logic [1:0]           timeSel,
  input  logic [1:0]           calSel,
  input  logic [NUM_FLAGS-1:0] wrData,
  input  logic                 clrWr,
  input  logic                 ienWr,
  input  logic                 idisWr,
  output logic [NUM_FLAGS-1:0] status,
  output logic [NUM_FLAGS-1:0] mask,
  output logic                 irq
);

  strobe_t strobe;

  tev_event_detect #(
    .MONDAY_CODE (MONDAY_CODE),
    .NOON_HOUR   (NOON_HOUR)
  ) u_detect (
    .clk       (clk),
    .rstN      (rstN),
    .secBcd    (secBcd),
    .minBcd    (minBcd),
    .hourBcd   (hourBcd),
    .dayOfWeek (dayOfWeek),
    .dateBcd   (dateBcd),
    .monthBcd  (monthBcd),
    .alarmHit  (alarmHit),
    .updAck    (updAck),
    .timeErr   (timeErr),
    .timeSel   (timeSel),
    .calSel    (calSel),
    .wrData    (wrData),
    .clrWr     (clrWr),
    .ienWr     (ienWr),
    .idisWr    (idisWr),
    .strobe    (strobe)
  );

  tev_flag_bank u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .status (status),
    .mask   (mask),
    .irq    (irq)
  );

endmodule

// File: rtl/tev_checker.sv
module tev_checker
  import tev_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           calSel,
  input logic [NUM_FLAGS-1:0] wrData,
  input logic                 clrWr,
  input logic                 ienWr,
  input logic                 idisWr,
  input logic [NUM_FLAGS-1:0] setVec,
  input logic [NUM_FLAGS-1:0] status,
  input logic [NUM_FLAGS-1:0] mask,
  input logic                 irq
);

  logic [NUM_FLAGS-1:0] clrSel;
  assign clrSel = clrWr ? wrData : '0;

  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (status == '0 && mask == '0 && !irq));

  // R6
  a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (calSel == 2'd3) |-> !setVec[FLG_CAL]);

  // R9
  a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((status & $past(wrData & ~setVec)) == '0));

  // R7 and R9: a flag only falls when a clear command names it
  a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(status) & ~status) & ~$past(clrSel)) == '0));

  // R10
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((status & $past(setVec)) == $past(setVec)));

  // R11
  a_r11_enable: assert property (@(posedge clk) disable iff (!rstN)
    (ienWr && !idisWr) |=> ((mask & $past(wrData)) == $past(wrData)));

  // R11
  a_r11_disable: assert property (@(posedge clk) disable iff (!rstN)
    idisWr |=> ((mask & $past(wrData)) == '0));

  // R12
  a_r12_irq_lag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == |($past(status & mask))));

endmodule

bind time_event_status tev_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .calSel (calSel),
  .wrData (wrData),
  .clrWr  (clrWr),
  .ienWr  (ienWr),
  .idisWr (idisWr),
  .setVec (strobe.setVec),
  .status (status),
  .mask   (mask),
  .irq    (irq)
);

// File: tb/time_event_status_test.sv
module time_event_status_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] secIn = 7'h58;
  logic [6:0] minIn = 7'h59;
  logic [5:0] hourIn = 6'h23;
  logic [2:0] dowIn = 3'd7;
  logic [5:0] dateIn = 6'h28;
  logic [4:0] monthIn = 5'h02;
  logic       alarmIn = 1'b0, ackIn = 1'b0, errIn = 1'b0;
  logic [1:0] tSelIn = 2'd0, cSelIn = 2'd0;
  logic [5:0] wrIn = 6'd0;
  logic       clrIn = 1'b0, ienIn = 1'b0, idisIn = 1'b0;
  logic [5:0] status, mask;
  logic       irq;

  int errors = 0;
  int checks = 0;
  string curTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  time_event_status uut (
    .clk(clk), .rstN(rstN), .secBcd(secIn), .minBcd(minIn), .hourBcd(hourIn),
    .dayOfWeek(dowIn), .dateBcd(dateIn), .monthBcd(monthIn),
    .alarmHit(alarmIn), .updAck(ackIn), .timeErr(errIn),
    .timeSel(tSelIn), .calSel(cSelIn), .wrData(wrIn),
    .clrWr(clrIn), .ienWr(ienIn), .idisWr(idisIn),
    .status(status), .mask(mask), .irq(irq)
  );

  // Behavioural reference model, stepped on every rising edge.
  int  lastH, lastM, lastS;
  bit  warm;
  bit [5:0] stM, mkM;
  bit  irqM;
  bit [5:0] raise;
  bit  moved, midnightNow;

  always @(posedge clk) begin
    if (!rstN) begin
      stM = 0; mkM = 0; irqM = 0; warm = 0;
      lastH = 0; lastM = 0; lastS = 0;
    end else begin
      irqM = |(stM & mkM);
      raise = 0;
      if (warm) begin
        moved = (hourIn != lastH) || (minIn != lastM) || (secIn != lastS);
        midnightNow = moved && hourIn == 0 && minIn == 0 && secIn == 0;
        if (secIn != lastS) raise[2] = 1;
        if (tSelIn == 0 && minIn != lastM && secIn == 0) raise[3] = 1;
        if (tSelIn == 1 && hourIn != lastH && minIn == 0 && secIn == 0) raise[3] = 1;
        if (tSelIn == 2 && midnightNow) raise[3] = 1;
        if (tSelIn == 3 && moved && hourIn == 6'h12 && minIn == 0 && secIn == 0) raise[3] = 1;
        if (midnightNow) begin
          if (cSelIn == 0 && dowIn == 1) raise[4] = 1;
          if (cSelIn == 1 && dateIn == 1) raise[4] = 1;
          if (cSelIn == 2 && dateIn == 1 && monthIn == 1) raise[4] = 1;
        end
      end
      raise[0] = ackIn;
      raise[1] = alarmIn;
      raise[5] = errIn;
      for (int i = 0; i < 6; i++) begin
        if (raise[i]) stM[i] = 1;
        else if (clrIn && wrIn[i]) stM[i] = 0;
        if (idisIn && wrIn[i]) mkM[i] = 0;
        else if (ienIn && wrIn[i]) mkM[i] = 1;
      end
      lastH = hourIn; lastM = minIn; lastS = secIn;
      warm = 1;
    end
  end

  // Cycle-by-cycle comparison, away from the rising edge.
  always @(negedge clk) begin
    checks += 3;
    if (status !== stM) begin
      errors++;
      $display("FAIL %s status: actual=%h expected=%h", curTag, status, stM);
    end
    if (mask !== mkM) begin
      errors++;
      $display("FAIL %s mask: actual=%h expected=%h", curTag, mask, mkM);
    end
    if (irq !== irqM) begin
      errors++;
      $display("FAIL %s irq: actual=%b expected=%b", curTag, irq, irqM);
    end
  end

  task automatic expectVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present a time and let one rising edge sample it; returns at the next falling edge.
  task automatic put(input logic [5:0] h, input logic [6:0] m, input logic [6:0] s);
    hourIn = h; minIn = m; secIn = s;
    @(negedge clk);
  endtask

  task automatic clearAll();
    wrIn = 6'h3f; clrIn = 1'b1;
    @(negedge clk);
    clrIn = 1'b0; wrIn = 6'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    curTag = "R1";
    expectVal("R1 status in reset", status, 0);
    expectVal("R1 mask in reset", mask, 0);
    rstN = 1'b1;
    @(negedge clk);
    expectVal("R1 status after release", status, 0);
    put(6'h23, 7'h59, 7'h58);

    curTag = "R2";
    put(6'h23, 7'h59, 7'h59);
    expectVal("R2 second flag", status[2], 1);
    expectVal("R3 no minute event at sec 59", status[3], 0);

    curTag = "R7";
    clearAll();
    repeat (4) @(negedge clk);
    expectVal("R7 held inputs stay quiet", status, 0);

    curTag = "R3";
    tSelIn = 2'd0;
    put(6'h10, 7'h00, 7'h59);
    clearAll();
    put(6'h10, 7'h01, 7'h00);
    expectVal("R3 minute event", status[3], 1);
    clearAll();
    put(6'h10, 7'h01, 7'h01);
    expectVal("R3 no event mid-minute", status[3], 0);
    tSelIn = 2'd1;
    put(6'h10, 7'h59, 7'h59);
    clearAll();
    put(6'h11, 7'h00, 7'h00);
    expectVal("R3 hour event", status[3], 1);
    clearAll();
    put(6'h11, 7'h01, 7'h00);
    expectVal("R3 minute change under hour select", status[3], 0);

    curTag = "R4";
    tSelIn = 2'd3;
    put(6'h11, 7'h59, 7'h59);
    clearAll();
    put(6'h12, 7'h00, 7'h00);
    expectVal("R4 noon event", status[3], 1);
    tSelIn = 2'd2;
    put(6'h12, 7'h00, 7'h01);
    clearAll();
    put(6'h12, 7'h00, 7'h00);
    expectVal("R4 noon under midnight select", status[3], 0);

    curTag = "R5";
    cSelIn = 2'd0;
    put(6'h23, 7'h59, 7'h59);
    clearAll();
    dowIn = 3'd1; dateIn = 6'h15; monthIn = 5'h06;
    put(6'h00, 7'h00, 7'h00);
    expectVal("R4 midnight event", status[3], 1);
    expectVal("R5 week event on Monday", status[4], 1);

    cSelIn = 2'd1;
    put(6'h23, 7'h59, 7'h59);
    clearAll();
    dowIn = 3'd2;
    put(6'h00, 7'h00, 7'h00);
    expectVal("R5 month select mid-month", status[4], 0);
    put(6'h23, 7'h59, 7'h59);
    dowIn = 3'd3; dateIn = 6'h01; monthIn = 5'h07;
    put(6'h00, 7'h00, 7'h00);
    expectVal("R5 month event on the first", status[4], 1);

    cSelIn = 2'd2;
    put(6'h23, 7'h59, 7'h59);
    clearAll();
    dateIn = 6'h01; monthIn = 5'h05;
    put(6'h00, 7'h00, 7'h00);
    expectVal("R5 year select in May", status[4], 0);
    put(6'h23, 7'h59, 7'h59);
    monthIn = 5'h01;
    put(6'h00, 7'h00, 7'h00);
    expectVal("R5 year event on January 1", status[4], 1);

    curTag = "R6";
    cSelIn = 2'd3;
    put(6'h23, 7'h59, 7'h59);
    clearAll();
    dowIn = 3'd1;
    put(6'h00, 7'h00, 7'h00);
    expectVal("R6 reserved select silent", status[4], 0);

    curTag = "R10";
    put(6'h23, 7'h59, 7'h59);
    wrIn = 6'h3f; clrIn = 1'b1;
    put(6'h00, 7'h00, 7'h00);
    clrIn = 1'b0; wrIn = 6'h00;
    expectVal("R10 set beats clear", status, 6'h0c);

    curTag = "R8";
    clearAll();
    alarmIn = 1'b1; @(negedge clk); alarmIn = 1'b0;
    ackIn = 1'b1;   @(negedge clk); ackIn = 1'b0;
    errIn = 1'b1;   @(negedge clk); errIn = 1'b0;
    @(negedge clk);
    expectVal("R8 pulse flags sticky", status, 6'h23);

    curTag = "R9";
    wrIn = 6'h00; clrIn = 1'b1; @(negedge clk); clrIn = 1'b0;
    expectVal("R9 zero clear no effect", status, 6'h23);
    wrIn = 6'h01; clrIn = 1'b1; @(negedge clk); clrIn = 1'b0; wrIn = 6'h00;
    expectVal("R9 single bit cleared", status, 6'h22);

    curTag = "R12";
    wrIn = 6'h02; ienIn = 1'b1; @(negedge clk); ienIn = 1'b0; wrIn = 6'h00;
    expectVal("R11 enable sets mask", mask, 6'h02);
    expectVal("R12 irq lags mask by a clock", irq, 0);
    @(negedge clk);
    expectVal("R12 irq raised", irq, 1);

    curTag = "R11";
    wrIn = 6'h06; ienIn = 1'b1; idisIn = 1'b1; @(negedge clk);
    ienIn = 1'b0; idisIn = 1'b0; wrIn = 6'h00;
    expectVal("R11 disable beats enable", mask, 6'h00);
    @(negedge clk);
    expectVal("R12 irq drops", irq, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule